// File: doc/BRIEF.md
# Asynchronous Static Memory Write Sequencer

This block carries out one asynchronous write cycle on an external static memory (SRAM, PSRAM or NOR-type) for each request it accepts. The address and data are captured when the request is taken. The block then steps through a fixed series of timed phases on the memory pins: an address setup phase, an optional address hold phase, and a data phase with write enable asserted. After the data phase it releases chip enable and raises a one-cycle completion pulse.

The length of each phase is a runtime field given in controller clock cycles. The bus can be separate (address and data on their own pins) or multiplexed (address and data share one bus, qualified by an address-valid strobe). Two controls decide whether the address hold phase runs: a multiplexed-bus flag, and an access-mode select that only counts when an extended-timing enable is high. Reserved and illegal zero settings are mapped to one cycle so that no required phase disappears. The timing fields are static inputs and are expected to stay steady while a write is in progress.

Top module: `sms_write_seq`

## Requirements
- R1: After a synchronous reset the outputs read: chip enable, write enable and address-valid inactive (all high), bus drive enable 0, bus and address outputs 0, done 0, ready 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Chip enable goes low in the cycle right after that edge, and `req_ready` stays low until the write has completed.
- R3: The setup phase lasts `cfg_setup` cycles (4-bit field, 0 to 15). On a separate bus a value of 0 leaves out the setup phase entirely.
- R4: On a multiplexed bus (`cfg_mux`=1), a setup value of 0 is treated as 1. Address-valid is low in exactly the setup cycles. During setup and hold, the bus carries the low bus-width bits of the address.
- R5: The hold phase runs when `cfg_mux`=1, or when `cfg_ext`=1 and `cfg_mode`=3. It lasts `cfg_hold` cycles (1 to 15), and a value of 0 is treated as 1.
- R6: Write enable is low for exactly `cfg_data` cycles (1 to 255), and a value of 0 is treated as 1. The bus carries the captured data throughout the data phase.
- R7: When `cfg_ext`=0, `cfg_mode` is ignored. Mode codes 0, 1 and 2 on a separate bus add no hold phase.
- R8: The phases always run in the order setup, hold, data. Chip enable stays low without a break from the first setup cycle to the last data cycle. Write enable is never low outside the data phase. The bus drive enable and the full address output stay valid while chip enable is low.
- R9: `done` is high for exactly one cycle, the first cycle in which chip enable is high again. `req_ready` returns high in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| cfg_setup | input | SETUP_W | Address setup length in cycles |
| cfg_hold | input | HOLD_W | Address hold length in cycles |
| cfg_data | input | DATA_W | Data phase length in cycles |
| cfg_mux | input | 1 | Multiplexed address/data bus |
| cfg_ext | input | 1 | Enables the access-mode select |
| cfg_mode | input | 2 | Access mode code 0..3 |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid, active low (multiplexed bus) |
| mem_bus_oe | output | 1 | Drive enable for the bus output |
| mem_bus | output | DW | Bus output value (address or data) |
| mem_addr | output | AW | Address pins |
| wr_done | output | 1 | One-cycle completion pulse |

## Verification
Random writes mix both bus types, every extended-mode and mode-code combination, and random setup, hold and data lengths. Each cycle of each write is compared with a trace computed from the requirements. Comparing a separate bus against a multiplexed one checks when address-valid is driven and what the bus carries in each phase. Toggling the extended enable against mode 3 checks that the hold phase is gated. Directed writes use zero setup, hold and data values on both bus types, and the maximum lengths of 15, 15 and 255. These show the zero-length setup on a separate bus, the clamp to one cycle in multiplexed mode, the mapping of reserved values, and counting at the full field width. Back-to-back writes check that `done` and `req_ready` return in the right cycles.

// File: rtl/sms_pkg.sv
package sms_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_HOLD  = 3'd2,
    PH_DATA  = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

  localparam logic [1:0] MODE_HOLD_CODE = 2'd3;

  function automatic logic phase_active(input phase_e p);
    return (p == PH_SETUP) || (p == PH_HOLD) || (p == PH_DATA);
  endfunction

endpackage

// File: rtl/sms_cfg_resolve.sv
module sms_cfg_resolve #(
  parameter int SETUP_W = 4,
  parameter int HOLD_W  = 4,
  parameter int DATA_W  = 8,
  parameter int CW      = 8
) (
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic [DATA_W-1:0]  cfg_data,
  input  logic               cfg_mux,
  input  logic               cfg_ext,
  input  logic [1:0]         cfg_mode,
  output logic [CW-1:0]      setup_len,
  output logic [CW-1:0]      hold_len,
  output logic [CW-1:0]      data_len,
  output logic               setup_skip,
  output logic               hold_en
);
  import sms_pkg::*;

  logic [CW-1:0] setup_raw, hold_raw, data_raw;

  assign setup_raw = CW'(cfg_setup);
  assign hold_raw  = CW'(cfg_hold);
  assign data_raw  = CW'(cfg_data);

  // Multiplexed bus needs at least one setup cycle to latch the address.
  always_comb begin
    if (cfg_mux && (setup_raw == '0)) setup_len = CW'(1);
    else                              setup_len = setup_raw;
  end

  assign setup_skip = (setup_len == '0);

  // Reserved zero encodings fall back to the shortest legal phase.
  assign hold_len = (hold_raw == '0) ? CW'(1) : hold_raw;
  assign data_len = (data_raw == '0) ? CW'(1) : data_raw;

  // Mode select counts only when the extended-timing enable is set.
  assign hold_en = cfg_mux || (cfg_ext && (cfg_mode == MODE_HOLD_CODE));

  always_comb begin
    assert (data_len != '0) else $error("p_data_nonzero_r6");
    assert (!(cfg_mux && setup_skip)) else $error("p_mux_setup_min_r4");
  end

endmodule

// File: rtl/sms_phase_timer.sv
module sms_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_len - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign last = (cnt_q == '0);

  always_comb begin
    if (load) assert (load_len != '0) else $error("p_no_zero_load_r6");
  end

endmodule

// File: rtl/sms_bus_drive.sv
module sms_bus_drive #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  sms_pkg::phase_e nxt_phase,
  input  logic           mux,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  data,
  output logic           ce_n,
  output logic           we_n,
  output logic           adv_n,
  output logic           bus_oe,
  output logic [DW-1:0]  bus,
  output logic [AW-1:0]  addr_out,
  output logic           done,
  output logic           ready
);
  import sms_pkg::*;

  logic [DW-1:0] addr_on_bus;

  generate
    if (AW >= DW) begin : g_addr_trunc
      assign addr_on_bus = addr[DW-1:0];
    end else begin : g_addr_ext
      assign addr_on_bus = {{(DW-AW){1'b0}}, addr};
    end
  endgenerate

  logic active;
  assign active = phase_active(nxt_phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n     <= 1'b1;
      we_n     <= 1'b1;
      adv_n    <= 1'b1;
      bus_oe   <= 1'b0;
      bus      <= '0;
      addr_out <= '0;
      done     <= 1'b0;
      ready    <= 1'b1;
    end else begin
      ce_n     <= !active;
      we_n     <= (nxt_phase != PH_DATA);
      adv_n    <= !(mux && (nxt_phase == PH_SETUP));
      bus_oe   <= active;
      addr_out <= active ? addr : '0;
      if (!active)                           bus <= '0;
      else if (mux && (nxt_phase != PH_DATA)) bus <= addr_on_bus;
      else                                   bus <= data;
      done     <= (nxt_phase == PH_DONE);
      ready    <= (nxt_phase == PH_IDLE);
    end
  end

  p_we_inside_ce_r8: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !ce_n);
  p_adv_not_with_we_r4: assert property (@(posedge clk) disable iff (rst)
    !adv_n |-> (we_n && !ce_n));
  p_done_on_release_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ce_n) |-> done);
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && ready));
  p_ready_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ce_n && !bus_oe));

endmodule

// File: rtl/sms_write_seq.sv
module sms_write_seq #(
  parameter int AW      = 20,
  parameter int DW      = 16,
  parameter int SETUP_W = 4,
  parameter int HOLD_W  = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_data,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic [DATA_W-1:0]  cfg_data,
  input  logic               cfg_mux,
  input  logic               cfg_ext,
  input  logic [1:0]         cfg_mode,
  output logic               mem_ce_n,
  output logic               mem_we_n,
  output logic               mem_adv_n,
  output logic               mem_bus_oe,
  output logic [DW-1:0]      mem_bus,
  output logic [AW-1:0]      mem_addr,
  output logic               wr_done
);
  import sms_pkg::*;

  localparam int MAXW_SH = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
  localparam int CW      = (DATA_W > MAXW_SH) ? DATA_W : MAXW_SH;

  phase_e        ph_q, ph_nxt;
  logic [CW-1:0] setup_len, hold_len, data_len, ld_len;
  logic          setup_skip, hold_en, ld, t_last, accept;
  logic [AW-1:0] addr_q, addr_sel;
  logic [DW-1:0] data_q, data_sel;
  logic          mux_q, mux_sel;

  sms_cfg_resolve #(
    .SETUP_W(SETUP_W), .HOLD_W(HOLD_W), .DATA_W(DATA_W), .CW(CW)
  ) u_cfg (
    .cfg_setup (cfg_setup),
    .cfg_hold  (cfg_hold),
    .cfg_data  (cfg_data),
    .cfg_mux   (cfg_mux),
    .cfg_ext   (cfg_ext),
    .cfg_mode  (cfg_mode),
    .setup_len (setup_len),
    .hold_len  (hold_len),
    .data_len  (data_len),
    .setup_skip(setup_skip),
    .hold_en   (hold_en)
  );

  sms_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (ld),
    .load_len(ld_len),
    .last    (t_last)
  );

  assign accept = (ph_q == PH_IDLE) && req_valid;

  always_comb begin
    ph_nxt = ph_q;
    ld     = 1'b0;
    ld_len = '0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          ld = 1'b1;
          if (!setup_skip) begin
            ph_nxt = PH_SETUP; ld_len = setup_len;
          end else if (hold_en) begin
            ph_nxt = PH_HOLD;  ld_len = hold_len;
          end else begin
            ph_nxt = PH_DATA;  ld_len = data_len;
          end
        end
      end
      PH_SETUP: begin
        if (t_last) begin
          ld = 1'b1;
          if (hold_en) begin
            ph_nxt = PH_HOLD; ld_len = hold_len;
          end else begin
            ph_nxt = PH_DATA; ld_len = data_len;
          end
        end
      end
      PH_HOLD: begin
        if (t_last) begin
          ld = 1'b1; ph_nxt = PH_DATA; ld_len = data_len;
        end
      end
      PH_DATA: begin
        if (t_last) ph_nxt = PH_DONE;
      end
      PH_DONE:  ph_nxt = PH_IDLE;
      default:  ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
      data_q <= '0;
      mux_q  <= 1'b0;
    end else begin
      ph_q <= ph_nxt;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_data;
        mux_q  <= cfg_mux;
      end
    end
  end

  assign addr_sel = accept ? req_addr : addr_q;
  assign data_sel = accept ? req_data : data_q;
  assign mux_sel  = accept ? cfg_mux  : mux_q;

  sms_bus_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .nxt_phase(ph_nxt),
    .mux      (mux_sel),
    .addr     (addr_sel),
    .data     (data_sel),
    .ce_n     (mem_ce_n),
    .we_n     (mem_we_n),
    .adv_n    (mem_adv_n),
    .bus_oe   (mem_bus_oe),
    .bus      (mem_bus),
    .addr_out (mem_addr),
    .done     (wr_done),
    .ready    (req_ready)
  );

  p_order_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_HOLD) |=> (ph_q == PH_HOLD) || (ph_q == PH_DATA));
  p_order_data_r8: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DATA) |=> (ph_q == PH_DATA) || (ph_q == PH_DONE));
  p_take_only_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE && req_valid) |=> !mem_ce_n);
  p_hold_gated_r5: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_HOLD) |-> hold_en);

endmodule

// File: tb/sms_write_seq_tb.sv
module sms_write_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [3:0]    cfg_setup = 4'd15;
  logic [3:0]    cfg_hold  = 4'd15;
  logic [7:0]    cfg_data  = 8'd255;
  logic          cfg_mux = 1'b0;
  logic          cfg_ext = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic          mem_ce_n, mem_we_n, mem_adv_n, mem_bus_oe, wr_done;
  logic [DW-1:0] mem_bus;
  logic [AW-1:0] mem_addr;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sms_write_seq #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .cfg_setup(cfg_setup),
    .cfg_hold(cfg_hold), .cfg_data(cfg_data), .cfg_mux(cfg_mux),
    .cfg_ext(cfg_ext), .cfg_mode(cfg_mode), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n), .mem_bus_oe(mem_bus_oe),
    .mem_bus(mem_bus), .mem_addr(mem_addr), .wr_done(wr_done)
  );

  // Port snapshot: ce, we, adv, oe, done, ready, bus, addr
  localparam int TW = 6 + DW + AW;

  function automatic logic [TW-1:0] pack(input logic ce, we, adv, oe, dn, rdy,
                                         input logic [DW-1:0] b,
                                         input logic [AW-1:0] a);
    return {ce, we, adv, oe, dn, rdy, b, a};
  endfunction

  function automatic int exp_setup(input logic mux, input logic [3:0] s);
    return (mux && s == 0) ? 1 : int'(s);
  endfunction

  function automatic int exp_hold(input logic mux, ext, input logic [1:0] m,
                                  input logic [3:0] h);
    if (!(mux || (ext && m == 2'd3))) return 0;
    return (h == 0) ? 1 : int'(h);
  endfunction

  function automatic int exp_data(input logic [7:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  task automatic compare(input logic [TW-1:0] exp, input string req, input int cyc);
    logic [TW-1:0] act;
    act = pack(mem_ce_n, mem_we_n, mem_adv_n, mem_bus_oe, wr_done, req_ready,
               mem_bus, mem_addr);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic run_write(input logic [3:0] s, input logic [3:0] h,
                           input logic [7:0] d, input logic mux, ext,
                           input logic [1:0] m, input logic [AW-1:0] a,
                           input logic [DW-1:0] v);
    int ns, nh, nd;
    logic [DW-1:0] abus;
    ns = exp_setup(mux, s);
    nh = exp_hold(mux, ext, m, h);
    nd = exp_data(d);
    abus = a[DW-1:0];
    @(negedge clk);
    cfg_setup = s; cfg_hold = h; cfg_data = d;
    cfg_mux = mux; cfg_ext = ext; cfg_mode = m;
    req_addr = a; req_data = v; req_valid = 1'b1;
    // R2: idle before the request
    compare(pack(1, 1, 1, 0, 0, 1, '0, '0), "R2 ready", -1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < ns + nh + nd + 2; i++) begin
      if (i < ns)                   // R3 / R4 setup
        compare(pack(0, 1, !mux, 1, 0, 0, mux ? abus : v, a), "R3/R4 setup", i);
      else if (i < ns + nh)         // R5 / R7 hold
        compare(pack(0, 1, 1, 1, 0, 0, mux ? abus : v, a), "R5/R7 hold", i);
      else if (i < ns + nh + nd)    // R6 / R8 data
        compare(pack(0, 0, 1, 1, 0, 0, v, a), "R6/R8 data", i);
      else if (i == ns + nh + nd)   // R9 release
        compare(pack(1, 1, 1, 0, 1, 0, '0, '0), "R9 done", i);
      else                          // R9 ready back
        compare(pack(1, 1, 1, 0, 0, 1, '0, '0), "R9 ready", i);
      if (i < ns + nh + nd + 1) @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51A7_E00D));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    compare(pack(1, 1, 1, 0, 0, 1, '0, '0), "R1 reset", 0);

    // R3: zero setup on a separate bus removes the phase
    run_write(4'd0, 4'd3, 8'd2, 1'b0, 1'b0, 2'd0, 20'hABCDE, 16'h1234);
    // R4: zero setup in multiplexed mode is one cycle
    run_write(4'd0, 4'd2, 8'd3, 1'b1, 1'b0, 2'd0, 20'h13579, 16'hBEEF);
    // R5 / R6: reserved zero hold and data map to one cycle
    run_write(4'd1, 4'd0, 8'd0, 1'b1, 1'b0, 2'd0, 20'h0F0F0, 16'hA5A5);
    run_write(4'd2, 4'd0, 8'd0, 1'b0, 1'b1, 2'd3, 20'h00001, 16'h0001);
    // R7: mode 3 ignored when extended timing is off; modes 0..2 add no hold
    run_write(4'd2, 4'd4, 8'd2, 1'b0, 1'b0, 2'd3, 20'h22222, 16'h3333);
    run_write(4'd2, 4'd4, 8'd2, 1'b0, 1'b1, 2'd1, 20'h44444, 16'h5555);
    run_write(4'd2, 4'd4, 8'd2, 1'b0, 1'b1, 2'd3, 20'h66666, 16'h7777);
    // R6: maximum lengths
    run_write(4'd15, 4'd15, 8'd255, 1'b1, 1'b1, 2'd3, 20'hFFFFF, 16'hFFFF);

    for (int k = 0; k < 60; k++) begin
      run_write(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                8'($urandom_range(0, 40)), 1'($urandom), 1'($urandom),
                2'($urandom), 20'($urandom), 16'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule